// File: doc/BRIEF.md
# Windowed Pixel-Array Readout Sequencer

This block produces the frame and line timing for reading a pixel array through a programmable window. From a clock, an active-low reset, an enable line and a set of configuration words, it produces a frame sync pulse and a line-valid signal (HSYNC). It also produces a per-slot pixel strobe, the row and column address of the pixel being read, and a pulse on the final pixel of each frame. The pixel data path, the converters and any register interface are not part of this block.

After enable has been stable for two clocks, the sequencer runs a fixed start-up chain: a sensor reset, the programmed exposure and one line delay. It then issues the first frame sync. Each frame reads the effective window line by line. The effective height is clipped at the array's lower edge. When the programmed exposure is longer than the frame's readout, an idle gap is inserted before the next frame sync. Configuration is captured when the sequencer leaves idle and again at each frame start. Either continuous or single-shot operation can be selected.

Top module: `readout_sequencer`

## Requirements
- R1: After enable is taken high, the outputs stay low for 2 deglitch clocks, then ARRAY_H sensor-reset clocks, then the start-up exposure length, then ARRAY_W + hBlank clocks. Only then is vsync first asserted.
- R2: In window mode, pixel slot s of effective line l has rowAddr = rowStart + l and colAddr = colStart + s, for s from 0 to winWidth-1. Outside pixel slots, both addresses are 0.
- R3: When windowMode is 0, every line has ARRAY_W slots, the frame has ARRAY_H lines and addressing starts at row 0 and column 0. rowStart, colStart, winHeight and winWidth have no effect.
- R4: The effective height is winHeight when rowStart + winHeight + 1 <= ARRAY_H. Otherwise it is ARRAY_H - rowStart - 1.
- R5: Each line has 12 low clocks, then the pixel slots on consecutive clocks with pixStrobe high, then 12 low clocks, then hBlank low clocks. hBlank = 0 gives no extra clocks.
- R6: Each frame starts with vsync high for vBlank consecutive clocks, or for 1 clock when vBlank is 0. vsync is never high during a line.
- R7: When pixelUnit is 0, the exposure value is integTime[15:0] and the scale is 1; bits 23:16 are ignored. When pixelUnit is 1, the exposure value is all 24 bits and the scale is ARRAY_W. The start-up exposure length is the exposure value times the scale, and a length of 0 clocks is skipped.
- R8: In continuous mode, an idle gap follows the last line's blanking whenever the exposure value exceeds effective height × scale. With pixelUnit = 0 the gap is (value - height) × LINE_UNIT clocks. With pixelUnit = 1 it is (value - height × ARRAY_W) clocks. Otherwise the next vsync follows at once.
- R9: With snapshot = 1, exactly one frame is produced and all outputs then stay low while enable remains high. With snapshot = 0, frames repeat.
- R10: With hsClockStyle = 0, hsync equals pixStrobe. With hsClockStyle = 1, hsync is high only on even-numbered slots of a line (slot 0 is even).
- R11: Reset, or enable sampled low, returns the sequencer to idle with all outputs low. An enable pulse shorter than the deglitch time does not start a sequence.
- R12: Configuration changed during a frame does not affect that frame or the gap after it. The new values apply from the next vsync.
- R13: frameDone pulses for one clock, on the last pixel slot of the last effective line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, one pixel slot per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run request, deglitched internally |
| rowStart | input | ROW_W | First window row |
| colStart | input | COL_W | First window column |
| winHeight | input | ROW_W | Window height in lines |
| winWidth | input | COL_W | Window width in pixels (non-zero) |
| hBlank | input | 16 | Extra low clocks after each line's tail |
| vBlank | input | 16 | Frame sync pulse length |
| integTime | input | 24 | Exposure value |
| pixelUnit | input | 1 | 1: exposure counted in pixels, 0: in lines |
| windowMode | input | 1 | 1: window readout, 0: full array |
| snapshot | input | 1 | 1: single frame, 0: continuous |
| hsClockStyle | input | 1 | 1: hsync gated by pixel clock |
| vsync | output | 1 | Frame sync pulse |
| hsync | output | 1 | Line valid / gated pixel clock |
| pixStrobe | output | 1 | High on every pixel slot |
| rowAddr | output | ROW_W | Row of the current slot |
| colAddr | output | COL_W | Column of the current slot |
| frameDone | output | 1 | Last pixel of the frame |

## Verification
A wrong state or counter in this block shows up as a timing fault at the ports. A sync pulse moves by a clock, a slot is added or lost, or an address is off at the next pixel. The checks compare every output on every clock, so the first divergent cycle is reported. A bad start-up or gap length shifts the whole following frame and is caught at its first vsync. A fault in clipping or in capturing the configuration is caught within one line of the affected frame.

// File: rtl/readout_seq_pkg.sv
package readout_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEGLITCH,
    ST_SENSRST,
    ST_INTEG,
    ST_LINEDLY,
    ST_VSYNC,
    ST_HEAD,
    ST_ACTIVE,
    ST_TAIL,
    ST_HBLANK,
    ST_GAP,
    ST_DONE
  } seqState_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic capture;     // latch configuration, restart line count
    logic slotActive;  // current cycle is a pixel slot
  } seqStrobe_t;

endpackage

// File: rtl/readout_datapath.sv
module readout_datapath
  import readout_seq_pkg::*;
#(
  parameter int ARRAY_W   = 414,
  parameter int ARRAY_H   = 314,
  parameter int LINE_UNIT = 1024,
  localparam int ROW_W = $clog2(ARRAY_H + 1),
  localparam int COL_W = $clog2(ARRAY_W + 1),
  localparam int CNT_W = 26 + COL_W + $clog2(LINE_UNIT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seqStrobe_t       strobe,
  input  logic [ROW_W-1:0] rowStart,
  input  logic [COL_W-1:0] colStart,
  input  logic [ROW_W-1:0] winHeight,
  input  logic [COL_W-1:0] winWidth,
  input  logic [15:0]      hBlank,
  input  logic [15:0]      vBlank,
  input  logic [23:0]      integTime,
  input  logic             pixelUnit,
  input  logic             windowMode,
  input  logic             snapshot,
  input  logic             hsClockStyle,
  output logic             lastSlot,
  output logic             lastLine,
  output logic             linesDone,
  output logic             evenSlot,
  output logic             snapshotMode,
  output logic             hsClockMode,
  output logic [CNT_W-1:0] lenIntegStart,
  output logic [CNT_W-1:0] lenLineDly,
  output logic [CNT_W-1:0] lenVsync,
  output logic [CNT_W-1:0] lenHblank,
  output logic [CNT_W-1:0] lenGap,
  output logic [ROW_W-1:0] rowAddr,
  output logic [COL_W-1:0] colAddr
);

  logic [ROW_W-1:0] sRowStart, sHeight;
  logic [COL_W-1:0] sColStart, sWidth;
  logic [15:0]      sHblank, sVblank;
  logic [23:0]      sInteg;
  logic             sPixel, sWindow, sSnap, sHsClock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sRowStart <= '0;
      sColStart <= '0;
      sHeight   <= '0;
      sWidth    <= '0;
      sHblank   <= '0;
      sVblank   <= '0;
      sInteg    <= '0;
      sPixel    <= 1'b0;
      sWindow   <= 1'b0;
      sSnap     <= 1'b0;
      sHsClock  <= 1'b0;
    end else if (strobe.capture) begin
      sRowStart <= rowStart;
      sColStart <= colStart;
      sHeight   <= winHeight;
      sWidth    <= winWidth;
      sHblank   <= hBlank;
      sVblank   <= vBlank;
      sInteg    <= integTime;
      sPixel    <= pixelUnit;
      sWindow   <= windowMode;
      sSnap     <= snapshot;
      sHsClock  <= hsClockStyle;
    end
  end

  // Window geometry with clipping at the lower array edge
  logic [ROW_W+1:0] endSum;
  logic [ROW_W-1:0] winEffH, effH, rowBase;
  logic [COL_W-1:0] width, colBase;

  assign endSum  = (ROW_W+2)'(sRowStart) + (ROW_W+2)'(sHeight) + (ROW_W+2)'(1);
  assign winEffH = (endSum <= (ROW_W+2)'(ARRAY_H)) ? sHeight
                 : ROW_W'(ARRAY_H - 1 - int'(sRowStart));
  assign effH    = sWindow ? winEffH   : ROW_W'(ARRAY_H);
  assign width   = sWindow ? sWidth    : COL_W'(ARRAY_W);
  assign rowBase = sWindow ? sRowStart : '0;
  assign colBase = sWindow ? sColStart : '0;

  // Line and slot counters
  logic [ROW_W-1:0] lineIdx;
  logic [COL_W-1:0] slotIdx;

  assign lastSlot  = (slotIdx == width - COL_W'(1));
  assign lastLine  = (lineIdx == effH - ROW_W'(1));
  assign linesDone = (lineIdx == effH);
  assign evenSlot  = ~slotIdx[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lineIdx <= '0;
      slotIdx <= '0;
    end else begin
      if (strobe.capture) begin
        lineIdx <= '0;
        slotIdx <= '0;
      end else if (strobe.slotActive) begin
        if (lastSlot) begin
          slotIdx <= '0;
          lineIdx <= lineIdx + ROW_W'(1);
        end else begin
          slotIdx <= slotIdx + COL_W'(1);
        end
      end
    end
  end

  assign rowAddr = strobe.slotActive ? rowBase + lineIdx : '0;
  assign colAddr = strobe.slotActive ? colBase + slotIdx : '0;

  // Interval lengths
  logic [CNT_W-1:0] integCmp, effScaled;

  assign integCmp      = sPixel ? CNT_W'(sInteg) : CNT_W'(sInteg[15:0]);
  assign effScaled     = sPixel ? CNT_W'(effH) * CNT_W'(ARRAY_W) : CNT_W'(effH);
  assign lenIntegStart = sPixel ? integCmp * CNT_W'(ARRAY_W) : integCmp;
  assign lenLineDly    = CNT_W'(ARRAY_W) + CNT_W'(sHblank);
  assign lenVsync      = (sVblank == 16'd0) ? CNT_W'(1) : CNT_W'(sVblank);
  assign lenHblank     = CNT_W'(sHblank);

  always_comb begin
    lenGap = '0;
    if (integCmp > effScaled) begin
      lenGap = sPixel ? (integCmp - effScaled)
                      : (integCmp - effScaled) * CNT_W'(LINE_UNIT);
    end
  end

  assign snapshotMode = sSnap;
  assign hsClockMode  = sHsClock;

  // R2: a slot never lies beyond the window width
  assert_slot_in_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.slotActive |-> slotIdx < width);

  // R4: pixel slots only occur on effective (clipped) lines
  assert_line_in_height_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.slotActive |-> lineIdx < effH);

endmodule

// File: rtl/readout_ctrl.sv
module readout_ctrl
  import readout_seq_pkg::*;
#(
  parameter int ARRAY_W   = 414,
  parameter int ARRAY_H   = 314,
  parameter int LINE_UNIT = 1024,
  parameter int DEGLITCH  = 2,
  parameter int HEAD_CYC  = 12,
  parameter int TAIL_CYC  = 12,
  localparam int COL_W = $clog2(ARRAY_W + 1),
  localparam int CNT_W = 26 + COL_W + $clog2(LINE_UNIT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             lastSlot,
  input  logic             lastLine,
  input  logic             linesDone,
  input  logic             snapshotMode,
  input  logic [CNT_W-1:0] lenIntegStart,
  input  logic [CNT_W-1:0] lenLineDly,
  input  logic [CNT_W-1:0] lenVsync,
  input  logic [CNT_W-1:0] lenHblank,
  input  logic [CNT_W-1:0] lenGap,
  output seqStrobe_t       strobe,
  output logic             vsyncOut,
  output logic             pixValid,
  output logic             frameDone
);

  seqState_e state, nxt, afterLine;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    if (!linesDone)          afterLine = ST_HEAD;
    else if (snapshotMode)   afterLine = ST_DONE;
    else if (lenGap != '0)   afterLine = ST_GAP;
    else                     afterLine = ST_VSYNC;
  end

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:     nxt = ST_DEGLITCH;
      ST_DEGLITCH: if (cnt == CNT_W'(DEGLITCH - 1))
                     nxt = ST_SENSRST;
      ST_SENSRST:  if (cnt == CNT_W'(ARRAY_H - 1))
                     nxt = (lenIntegStart != '0) ? ST_INTEG : ST_LINEDLY;
      ST_INTEG:    if (cnt == lenIntegStart - CNT_W'(1)) nxt = ST_LINEDLY;
      ST_LINEDLY:  if (cnt == lenLineDly - CNT_W'(1))    nxt = ST_VSYNC;
      ST_VSYNC:    if (cnt == lenVsync - CNT_W'(1))      nxt = ST_HEAD;
      ST_HEAD:     if (cnt == CNT_W'(HEAD_CYC - 1))      nxt = ST_ACTIVE;
      ST_ACTIVE:   if (lastSlot)                         nxt = ST_TAIL;
      ST_TAIL:     if (cnt == CNT_W'(TAIL_CYC - 1))
                     nxt = (lenHblank != '0) ? ST_HBLANK : afterLine;
      ST_HBLANK:   if (cnt == lenHblank - CNT_W'(1))     nxt = afterLine;
      ST_GAP:      if (cnt == lenGap - CNT_W'(1))        nxt = ST_VSYNC;
      ST_DONE:     nxt = ST_DONE;
      default:     nxt = ST_IDLE;
    endcase
    if (!enable) nxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      cnt   <= (nxt != state) ? '0 : cnt + CNT_W'(1);
    end
  end

  assign strobe.capture    = (state == ST_IDLE && enable) ||
                             (nxt == ST_VSYNC && state != ST_VSYNC);
  assign strobe.slotActive = (state == ST_ACTIVE);
  assign vsyncOut  = (state == ST_VSYNC);
  assign pixValid  = (state == ST_ACTIVE);
  assign frameDone = (state == ST_ACTIVE) && lastSlot && lastLine;

  // R11: sensor reset only starts after enable held across the deglitch window
  assert_deglitch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_SENSRST) |-> ($past(enable) && $past(enable, 2)));

  // R5: pixel slots of a line are contiguous
  assert_slots_contiguous_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACTIVE && !lastSlot && enable) |=> state == ST_ACTIVE);

  // R13: frame-done is a single-cycle pulse followed by the line tail
  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (frameDone && enable) |=> (!frameDone && state == ST_TAIL));

endmodule

// File: rtl/readout_sequencer.sv
module readout_sequencer
  import readout_seq_pkg::*;
#(
  parameter int ARRAY_W   = 414,
  parameter int ARRAY_H   = 314,
  parameter int LINE_UNIT = 1024,
  localparam int ROW_W = $clog2(ARRAY_H + 1),
  localparam int COL_W = $clog2(ARRAY_W + 1),
  localparam int CNT_W = 26 + COL_W + $clog2(LINE_UNIT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [ROW_W-1:0] rowStart,
  input  logic [COL_W-1:0] colStart,
  input  logic [ROW_W-1:0] winHeight,
  input  logic [COL_W-1:0] winWidth,
  input  logic [15:0]      hBlank,
  input  logic [15:0]      vBlank,
  input  logic [23:0]      integTime,
  input  logic             pixelUnit,
  input  logic             windowMode,
  input  logic             snapshot,
  input  logic             hsClockStyle,
  output logic             vsync,
  output logic             hsync,
  output logic             pixStrobe,
  output logic [ROW_W-1:0] rowAddr,
  output logic [COL_W-1:0] colAddr,
  output logic             frameDone
);

  seqStrobe_t       strobe;
  logic             lastSlot, lastLine, linesDone, evenSlot;
  logic             snapshotMode, hsClockMode, pixValid;
  logic [CNT_W-1:0] lenIntegStart, lenLineDly, lenVsync, lenHblank, lenGap;

  readout_ctrl #(
    .ARRAY_W(ARRAY_W), .ARRAY_H(ARRAY_H), .LINE_UNIT(LINE_UNIT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .lastSlot(lastSlot), .lastLine(lastLine), .linesDone(linesDone),
    .snapshotMode(snapshotMode),
    .lenIntegStart(lenIntegStart), .lenLineDly(lenLineDly),
    .lenVsync(lenVsync), .lenHblank(lenHblank), .lenGap(lenGap),
    .strobe(strobe), .vsyncOut(vsync), .pixValid(pixValid),
    .frameDone(frameDone)
  );

  readout_datapath #(
    .ARRAY_W(ARRAY_W), .ARRAY_H(ARRAY_H), .LINE_UNIT(LINE_UNIT)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .rowStart(rowStart), .colStart(colStart),
    .winHeight(winHeight), .winWidth(winWidth),
    .hBlank(hBlank), .vBlank(vBlank), .integTime(integTime),
    .pixelUnit(pixelUnit), .windowMode(windowMode),
    .snapshot(snapshot), .hsClockStyle(hsClockStyle),
    .lastSlot(lastSlot), .lastLine(lastLine), .linesDone(linesDone),
    .evenSlot(evenSlot), .snapshotMode(snapshotMode),
    .hsClockMode(hsClockMode),
    .lenIntegStart(lenIntegStart), .lenLineDly(lenLineDly),
    .lenVsync(lenVsync), .lenHblank(lenHblank), .lenGap(lenGap),
    .rowAddr(rowAddr), .colAddr(colAddr)
  );

  assign pixStrobe = pixValid;
  assign hsync     = pixValid & (hsClockMode ? evenSlot : 1'b1);

  // R11: enable sampled low leaves every timing output low
  assert_idle_outputs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!vsync && !hsync && !pixStrobe && !frameDone));

  // R6: frame sync never overlaps a pixel slot
  assert_vsync_no_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |-> !pixStrobe);

endmodule

// File: tb/tb_readout_sequencer.sv
module tb_readout_sequencer;

  localparam int W  = 40;
  localparam int H  = 24;
  localparam int LU = 16;
  localparam int ROW_W = $clog2(H + 1);
  localparam int COL_W = $clog2(W + 1);

  typedef struct {
    int rs, cs, h, w, hb, vb, integ;
    bit pix, win, snap, hsc;
  } cfg_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [ROW_W-1:0] rowStart, winHeight, rowAddr;
  logic [COL_W-1:0] colStart, winWidth, colAddr;
  logic [15:0] hBlank, vBlank;
  logic [23:0] integTime;
  logic pixelUnit, windowMode, snapshot, hsClockStyle;
  logic vsync, hsync, pixStrobe, frameDone;

  int nChecks = 0;
  int nFail = 0;
  cfg_t cur;

  always #4 clk = ~clk;

  readout_sequencer #(.ARRAY_W(W), .ARRAY_H(H), .LINE_UNIT(LU)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .rowStart(rowStart), .colStart(colStart),
    .winHeight(winHeight), .winWidth(winWidth),
    .hBlank(hBlank), .vBlank(vBlank), .integTime(integTime),
    .pixelUnit(pixelUnit), .windowMode(windowMode),
    .snapshot(snapshot), .hsClockStyle(hsClockStyle),
    .vsync(vsync), .hsync(hsync), .pixStrobe(pixStrobe),
    .rowAddr(rowAddr), .colAddr(colAddr), .frameDone(frameDone)
  );

  task automatic drive(input cfg_t c);
    cur          = c;
    rowStart     = ROW_W'(c.rs);
    colStart     = COL_W'(c.cs);
    winHeight    = ROW_W'(c.h);
    winWidth     = COL_W'(c.w);
    hBlank       = 16'(c.hb);
    vBlank       = 16'(c.vb);
    integTime    = 24'(c.integ);
    pixelUnit    = c.pix;
    windowMode   = c.win;
    snapshot     = c.snap;
    hsClockStyle = c.hsc;
  endtask

  task automatic chk(input bit eVs, input bit eHs, input bit eSt, input bit eDn,
                     input int eRow, input int eCol, input string req);
    @(posedge clk); #1;
    nChecks++;
    if ({vsync, hsync, pixStrobe, frameDone} !== {eVs, eHs, eSt, eDn} ||
        rowAddr !== ROW_W'(eRow) || colAddr !== COL_W'(eCol)) begin
      nFail++;
      $display("FAIL %s t=%0t: got vs=%b hs=%b st=%b dn=%b row=%0d col=%0d, expected vs=%b hs=%b st=%b dn=%b row=%0d col=%0d",
               req, $time, vsync, hsync, pixStrobe, frameDone, rowAddr, colAddr,
               eVs, eHs, eSt, eDn, eRow, eCol);
    end
  endtask

  task automatic quiet(input int n, input string req);
    for (int i = 0; i < n; i++) chk(0, 0, 0, 0, 0, 0, req);
  endtask

  // Behavioural frame model: startup (optional), sync, lines, gap
  task automatic runFrame(input cfg_t c, input bit startup, input string tag);
    int effH, width, rb, cb, vlen, gap, expo, scale, ilen;
    if (c.win) begin
      effH  = (c.rs + c.h + 1 <= H) ? c.h : H - c.rs - 1;
      width = c.w; rb = c.rs; cb = c.cs;
    end else begin
      effH = H; width = W; rb = 0; cb = 0;
    end
    expo  = c.pix ? c.integ : (c.integ & 'hFFFF);
    scale = c.pix ? W : 1;
    ilen  = expo * scale;
    if (expo > effH * scale)
      gap = c.pix ? expo - effH * W : (expo - effH) * LU;
    else
      gap = 0;
    vlen = (c.vb == 0) ? 1 : c.vb;
    if (startup) begin
      quiet(2, "R11");
      quiet(H, "R1");
      quiet(ilen, "R7");
      quiet(W + c.hb, "R1");
    end
    for (int i = 0; i < vlen; i++) chk(1, 0, 0, 0, 0, 0, "R6");
    for (int l = 0; l < effH; l++) begin
      quiet(12, "R5");
      for (int s = 0; s < width; s++)
        chk(0, c.hsc ? (s % 2 == 0) : 1'b1, 1,
            (l == effH - 1) && (s == width - 1), rb + l, cb + s, tag);
      quiet(12, "R5");
      quiet(c.hb, "R5");
    end
    if (!c.snap) quiet(gap, "R8");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: run reached %0d cycles, expected completion earlier", 150000);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    cfg_t a, b, c, d;
    a = '{rs:6, cs:6, h:4, w:5, hb:3, vb:3, integ:2, pix:0, win:1, snap:0, hsc:0};
    // R7: bits 23:16 set, ignored in line units
    b = '{rs:6, cs:6, h:4, w:7, hb:3, vb:0, integ:'h3F000A, pix:0, win:1, snap:0, hsc:1};
    // R4: clipped height 24-20-1 = 3; pixel gap 130-3*40 = 10
    c = '{rs:20, cs:3, h:10, w:6, hb:2, vb:2, integ:130, pix:1, win:1, snap:0, hsc:1};
    // R3: full array, window values ignored; R9 snapshot
    d = '{rs:17, cs:9, h:3, w:2, hb:0, vb:0, integ:0, pix:0, win:0, snap:1, hsc:0};

    drive(a);
    quiet(3, "R11");                      // reset state
    #0 rst_n = 1'b1;
    quiet(3, "R11");

    // R11: one-clock enable pulse is rejected
    enable = 1'b1;
    chk(0, 0, 0, 0, 0, 0, "R11");
    enable = 1'b0;
    quiet(120, "R11");

    // R1 start-up and R2 window, continuous frames
    enable = 1'b1;
    runFrame(cur, 1, "R2");
    fork
      begin
        repeat (20) @(posedge clk);
        #1 drive(b);
      end
    join_none
    runFrame(cur, 0, "R12");               // still old config (R12)
    runFrame(cur, 0, "R10");               // new config, gap (R8, R7)
    runFrame(cur, 0, "R8");
    enable = 1'b0;
    quiet(30, "R11");

    // R4 clipping, pixel-unit gap
    drive(c);
    enable = 1'b1;
    runFrame(cur, 1, "R4");
    runFrame(cur, 0, "R4");
    enable = 1'b0;
    quiet(20, "R11");

    // R3 full array, R9 single shot, R13 done pulse
    drive(d);
    enable = 1'b1;
    runFrame(cur, 1, "R3");
    quiet(200, "R9");
    enable = 1'b0;
    quiet(5, "R11");

    // R11: reset in the middle of a frame
    drive(a);
    enable = 1'b1;
    runFrame(cur, 1, "R13");
    chk(1, 0, 0, 0, 0, 0, "R6");
    rst_n = 1'b0;
    quiet(10, "R11");
    rst_n = 1'b1;
    runFrame(cur, 1, "R1");

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule